// File: doc/BRIEF.md
# Three-Level Partial Shoot-Through PWM Sequencer

This block drives the twelve gate signals of a three-phase, three-level neutral-point-clamped bridge supplied through a single quasi impedance network. A free-running carrier counter defines a switching period of `PERIOD` clock cycles. At the first cycle of every period the block takes a fresh snapshot of its inputs: the three-level state of every leg for each of the three nearest voltage vectors, the dwell counts of the second and third vectors, a total shoot-through count, and the leg indices chosen for the upper and lower partial shoot-through.

Inside the period the vectors play centre-aligned: first, second, third, then third, second, first. The first vector takes all time left over by the other two. It is the vector whose zero-like time gets traded for boost. An upper partial shoot-through (three upper-side switches of one leg on) opens the period. A lower partial shoot-through of identical length (three lower-side switches of one leg on) closes it. A whole leg is never turned on at once, so the active states seen by the load keep their order and timing.

The space-vector duty computation, dead time and the outer control loops sit upstream and downstream of this block.

Top module: `npc3_stseq`

## Requirements
- R1: Leg k drives gates_o[4k+3:4k] as {Q1, Q2, Q1b, Q2b}. Level code 2'b10 (P) gives 4'b1100, 2'b01 (O) gives 4'b0110, 2'b00 (N) gives 4'b0011, and the unused code 2'b11 is treated as O. In each vector bus, leg k's code sits at bits [2k+1:2k].
- R2: While rst is high, and for the whole first period after it falls, every leg shows 4'b0110 and no shoot-through appears. period_start_o is low during reset.
- R3: No leg ever shows 4'b1111.
- R4: period_start_o pulses high for one cycle exactly PERIOD cycles after reset falls, and then every PERIOD cycles. The inputs are captured at the clock edge that starts that cycle. Input changes at any other time take effect only from the following period start.
- R5: The second-vector dwell is clipped to PERIOD. The third is clipped to whatever remains. The first vector gets the rest. Each dwell d is split as floor(d/2) cycles in the first half and d - floor(d/2) in the second half, in the order v1, v2, v3, v3, v2, v1.
- R6: Let u = min(floor(st_total/2), max(floor(d1/2) - 1, 0)). The leg named by ust_leg shows 4'b1110 during the first u cycles of the period. The leg named by lst_leg shows 4'b0111 during the last u cycles. Upper and lower counts are therefore always equal.
- R7: In a period where either leg index is 3, the upper-shoot-through leg is at N in the first vector, or the lower-shoot-through leg is at P in the first vector, u is forced to 0.
- R8: Legs not named by the shoot-through selects always show exactly their vector level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec1_lvl | input | 6 | Per-leg level codes of the first (remainder) vector |
| vec2_lvl | input | 6 | Per-leg level codes of the second vector |
| vec3_lvl | input | 6 | Per-leg level codes of the third vector |
| dwell2 | input | DW | Dwell of the second vector in cycles |
| dwell3 | input | DW | Dwell of the third vector in cycles |
| st_total | input | DW | Combined upper plus lower shoot-through cycles requested |
| ust_leg | input | 2 | Leg index for upper partial shoot-through (3 = none) |
| lst_leg | input | 2 | Leg index for lower partial shoot-through (3 = none) |
| gates_o | output | 12 | Gate commands, four per leg |
| period_start_o | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
A corrupted boundary or shoot-through length in the captured snapshot shows up at gates_o within the same period. It appears either as a leg level switching one or more cycles early or late, or as a mismatch between the upper and lower shoot-through counts. The latter is detected at the last cycle of that period. A carrier counter that wraps at the wrong count moves period_start_o and shifts every edge of the following period, so it is visible within at most one period. A wrong gate encoding is visible on the first cycle in which the affected level is played.

// File: rtl/npc3_stseq_pkg.sv
package npc3_stseq_pkg;

    localparam int NLEG = 3;
    localparam int TW   = 16;

    typedef logic [TW-1:0] tick_t;

    typedef enum logic [1:0] {
        LVL_N = 2'b00,
        LVL_O = 2'b01,
        LVL_P = 2'b10,
        LVL_X = 2'b11
    } lvl_e;

    localparam logic [3:0] G_P   = 4'b1100;
    localparam logic [3:0] G_O   = 4'b0110;
    localparam logic [3:0] G_N   = 4'b0011;
    localparam logic [3:0] G_UST = 4'b1110;
    localparam logic [3:0] G_LST = 4'b0111;

    typedef struct packed {
        tick_t       b1;
        tick_t       b2;
        tick_t       b3;
        tick_t       b4;
        tick_t       b5;
        tick_t       u;
        logic [5:0]  c1;
        logic [5:0]  c2;
        logic [5:0]  c3;
        logic [1:0]  ul;
        logic [1:0]  ll;
    } plan_t;

    function automatic lvl_e leg_code(input logic [5:0] codes, input logic [1:0] k);
        case (k)
            2'd0:    leg_code = lvl_e'(codes[1:0]);
            2'd1:    leg_code = lvl_e'(codes[3:2]);
            2'd2:    leg_code = lvl_e'(codes[5:4]);
            default: leg_code = LVL_O;
        endcase
    endfunction

    function automatic logic [3:0] lvl_gates(input lvl_e l);
        case (l)
            LVL_P:   lvl_gates = G_P;
            LVL_N:   lvl_gates = G_N;
            default: lvl_gates = G_O;
        endcase
    endfunction

endpackage

// File: rtl/npc3_stseq_timer.sv
module npc3_stseq_timer
    import npc3_stseq_pkg::*;
#(
    parameter int PERIOD = 40
) (
    input  logic  clk,
    input  logic  rst,
    output tick_t cnt,
    output logic  load,
    output logic  strobe
);
    localparam tick_t LAST = tick_t'(PERIOD - 1);

    tick_t cnt_q;
    logic  strobe_q;

    assign load   = (cnt_q == LAST);
    assign cnt    = cnt_q;
    assign strobe = strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            cnt_q    <= load ? '0 : cnt_q + tick_t'(1);
            strobe_q <= load;
        end
    end
endmodule

// File: rtl/npc3_stseq_plan.sv
module npc3_stseq_plan
    import npc3_stseq_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int DW     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [5:0]    vec1_lvl,
    input  logic [5:0]    vec2_lvl,
    input  logic [5:0]    vec3_lvl,
    input  logic [DW-1:0] dwell2,
    input  logic [DW-1:0] dwell3,
    input  logic [DW-1:0] st_total,
    input  logic [1:0]    ust_leg,
    input  logic [1:0]    lst_leg,
    output plan_t         plan
);
    localparam tick_t T = tick_t'(PERIOD);

    tick_t d1, d2c, d3c, rem;
    tick_t f1, f2, f3, s2, s3;
    tick_t half_st, lim;
    logic  st_ok;
    plan_t plan_d, plan_q;

    always_comb begin
        d2c     = (tick_t'(dwell2) > T) ? T : tick_t'(dwell2);
        rem     = T - d2c;
        d3c     = (tick_t'(dwell3) > rem) ? rem : tick_t'(dwell3);
        d1      = rem - d3c;
        f1      = d1 >> 1;
        f2      = d2c >> 1;
        f3      = d3c >> 1;
        s2      = d2c - f2;
        s3      = d3c - f3;
        half_st = tick_t'(st_total) >> 1;
        lim     = (f1 == '0) ? '0 : f1 - tick_t'(1);
        st_ok   = (ust_leg != 2'd3) && (lst_leg != 2'd3)
               && (leg_code(vec1_lvl, ust_leg) != LVL_N)
               && (leg_code(vec1_lvl, lst_leg) != LVL_P);

        plan_d.b1 = f1;
        plan_d.b2 = f1 + f2;
        plan_d.b3 = f1 + f2 + f3;
        plan_d.b4 = f1 + f2 + f3 + s3;
        plan_d.b5 = f1 + f2 + f3 + s3 + s2;
        plan_d.u  = st_ok ? ((half_st < lim) ? half_st : lim) : '0;
        plan_d.c1 = vec1_lvl;
        plan_d.c2 = vec2_lvl;
        plan_d.c3 = vec3_lvl;
        plan_d.ul = ust_leg;
        plan_d.ll = lst_leg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q.b1 <= '0;
            plan_q.b2 <= '0;
            plan_q.b3 <= '0;
            plan_q.b4 <= '0;
            plan_q.b5 <= '0;
            plan_q.u  <= '0;
            plan_q.c1 <= {3{LVL_O}};
            plan_q.c2 <= {3{LVL_O}};
            plan_q.c3 <= {3{LVL_O}};
            plan_q.ul <= 2'd3;
            plan_q.ll <= 2'd3;
        end else if (load) begin
            plan_q <= plan_d;
        end
    end

    assign plan = plan_q;
endmodule

// File: rtl/npc3_stseq_leg.sv
module npc3_stseq_leg
    import npc3_stseq_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int LEG    = 0
) (
    input  tick_t      cnt,
    input  plan_t      plan,
    output logic [3:0] gates
);
    localparam logic [1:0] MY_IDX = 2'(LEG);

    logic [5:0]  codes;
    tick_t       lst_from;
    logic        in_ust, in_lst;

    always_comb begin
        if (cnt < plan.b1)      codes = plan.c1;
        else if (cnt < plan.b2) codes = plan.c2;
        else if (cnt < plan.b4) codes = plan.c3;
        else if (cnt < plan.b5) codes = plan.c2;
        else                    codes = plan.c1;

        lst_from = tick_t'(PERIOD) - plan.u;
        in_ust   = (plan.ul == MY_IDX) && (cnt < plan.u);
        in_lst   = (plan.ll == MY_IDX) && (plan.u != '0) && (cnt >= lst_from);

        if (in_ust)      gates = G_UST;
        else if (in_lst) gates = G_LST;
        else             gates = lvl_gates(leg_code(codes, MY_IDX));
    end
endmodule

// File: rtl/npc3_stseq.sv
module npc3_stseq
    import npc3_stseq_pkg::*;
#(
    parameter int PERIOD = 40,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [5:0]    vec1_lvl,
    input  logic [5:0]    vec2_lvl,
    input  logic [5:0]    vec3_lvl,
    input  logic [DW-1:0] dwell2,
    input  logic [DW-1:0] dwell3,
    input  logic [DW-1:0] st_total,
    input  logic [1:0]    ust_leg,
    input  logic [1:0]    lst_leg,
    output logic [11:0]   gates_o,
    output logic          period_start_o
);
    tick_t cnt_w;
    logic  load_w;
    plan_t plan_w;

    npc3_stseq_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cnt    (cnt_w),
        .load   (load_w),
        .strobe (period_start_o)
    );

    npc3_stseq_plan #(.PERIOD(PERIOD), .DW(DW)) u_plan (
        .clk      (clk),
        .rst      (rst),
        .load     (load_w),
        .vec1_lvl (vec1_lvl),
        .vec2_lvl (vec2_lvl),
        .vec3_lvl (vec3_lvl),
        .dwell2   (dwell2),
        .dwell3   (dwell3),
        .st_total (st_total),
        .ust_leg  (ust_leg),
        .lst_leg  (lst_leg),
        .plan     (plan_w)
    );

    for (genvar k = 0; k < NLEG; k++) begin : g_leg
        npc3_stseq_leg #(.PERIOD(PERIOD), .LEG(k)) u_leg (
            .cnt   (cnt_w),
            .plan  (plan_w),
            .gates (gates_o[4*k +: 4])
        );
    end
endmodule

// File: rtl/npc3_stseq_chk.sv
module npc3_stseq_chk
    import npc3_stseq_pkg::*;
#(
    parameter int PERIOD = 40
) (
    input logic        clk,
    input logic        rst,
    input logic [11:0] gates,
    input logic        strobe,
    input tick_t       cnt
);
    localparam tick_t LAST = tick_t'(PERIOD - 1);
    localparam tick_t HALF = tick_t'(PERIOD / 2);

    logic  ust_now, lst_now;
    tick_t ust_acc, lst_acc;

    assign ust_now = (gates[3:0] == G_UST) || (gates[7:4] == G_UST) || (gates[11:8] == G_UST);
    assign lst_now = (gates[3:0] == G_LST) || (gates[7:4] == G_LST) || (gates[11:8] == G_LST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ust_acc <= '0;
            lst_acc <= '0;
        end else if (cnt == '0) begin
            ust_acc <= tick_t'(ust_now);
            lst_acc <= tick_t'(lst_now);
        end else begin
            ust_acc <= ust_acc + tick_t'(ust_now);
            lst_acc <= lst_acc + tick_t'(lst_now);
        end
        if (!rst && cnt == LAST) begin
            AST_ST_BALANCE: assert ((ust_acc + tick_t'(ust_now)) == (lst_acc + tick_t'(lst_now))) else $error("shoot-through imbalance"); // R6
        end
    end

    AST_NO_FULL_LEG: assert property (@(posedge clk) disable iff (rst) (gates[3:0] != 4'hF) && (gates[7:4] != 4'hF) && (gates[11:8] != 4'hF)); // R3
    AST_RESET_TO_O: assert property (@(posedge clk) rst |=> (gates == 12'h666) && !strobe); // R2
    AST_STROBE_AT_WRAP: assert property (@(posedge clk) disable iff (rst) strobe |-> (cnt == '0)); // R4
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) strobe |=> !strobe); // R4
    AST_UST_FIRST_HALF: assert property (@(posedge clk) disable iff (rst) ust_now |-> (cnt < HALF) && !lst_now); // R6
    AST_LST_SECOND_HALF: assert property (@(posedge clk) disable iff (rst) lst_now |-> (cnt >= HALF)); // R6
endmodule

bind npc3_stseq npc3_stseq_chk #(.PERIOD(PERIOD)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .gates  (gates_o),
    .strobe (period_start_o),
    .cnt    (cnt_w)
);

// File: tb/npc3_stseq_bench.sv
module npc3_stseq_bench;
    localparam int PERIOD = 40;
    localparam int DW     = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [15:0] d2;
        logic [15:0] d3;
        logic [15:0] st;
        logic [1:0]  ul;
        logic [1:0]  ll;
        logic [5:0]  c1;
        logic [5:0]  c2;
        logic [5:0]  c3;
    } cfg_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    vec1_lvl = 6'h15, vec2_lvl = 6'h15, vec3_lvl = 6'h15;
    logic [DW-1:0] dwell2 = '0, dwell3 = '0, st_total = '0;
    logic [1:0]    ust_leg = 2'd3, lst_leg = 2'd3;
    logic [11:0]   gates_o;
    logic          period_start_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    npc3_stseq #(.PERIOD(PERIOD)) u_npc3_stseq (
        .clk(clk), .rst(rst),
        .vec1_lvl(vec1_lvl), .vec2_lvl(vec2_lvl), .vec3_lvl(vec3_lvl),
        .dwell2(dwell2), .dwell3(dwell3), .st_total(st_total),
        .ust_leg(ust_leg), .lst_leg(lst_leg),
        .gates_o(gates_o), .period_start_o(period_start_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] enc(input logic [1:0] c);
        case (c)
            2'b10:   enc = 4'b1100;
            2'b00:   enc = 4'b0011;
            default: enc = 4'b0110;
        endcase
    endfunction

    function automatic int exp_u(input cfg_t c);
        int d2, rem, d3, d1, lim, hs;
        d2  = (int'(c.d2) > PERIOD) ? PERIOD : int'(c.d2);
        rem = PERIOD - d2;
        d3  = (int'(c.d3) > rem) ? rem : int'(c.d3);
        d1  = rem - d3;
        lim = (d1 / 2 > 0) ? d1 / 2 - 1 : 0;
        hs  = int'(c.st) / 2;
        if (c.ul == 2'd3 || c.ll == 2'd3) return 0;
        if (c.c1[2*c.ul +: 2] == 2'b00) return 0;
        if (c.c1[2*c.ll +: 2] == 2'b10) return 0;
        return (hs < lim) ? hs : lim;
    endfunction

    function automatic logic [11:0] model(input cfg_t c, input int p);
        int d2, rem, d3, d1, b1, b2, b3, b4, b5, u;
        logic [5:0]  v;
        logic [11:0] g;
        d2  = (int'(c.d2) > PERIOD) ? PERIOD : int'(c.d2);
        rem = PERIOD - d2;
        d3  = (int'(c.d3) > rem) ? rem : int'(c.d3);
        d1  = rem - d3;
        b1  = d1 / 2;
        b2  = b1 + d2 / 2;
        b3  = b2 + d3 / 2;
        b4  = b3 + (d3 - d3 / 2);
        b5  = b4 + (d2 - d2 / 2);
        if (p < b1)      v = c.c1;
        else if (p < b2) v = c.c2;
        else if (p < b3) v = c.c3;
        else if (p < b4) v = c.c3;
        else if (p < b5) v = c.c2;
        else             v = c.c1;
        for (int k = 0; k < 3; k++) g[4*k +: 4] = enc(v[2*k +: 2]);
        u = exp_u(c);
        if (u > 0 && p < u) g[4*c.ul +: 4] = 4'b1110;
        if (u > 0 && p >= PERIOD - u) g[4*c.ll +: 4] = 4'b0111;
        return g;
    endfunction

    task automatic apply(input cfg_t c);
        vec1_lvl = c.c1; vec2_lvl = c.c2; vec3_lvl = c.c3;
        dwell2 = DW'(c.d2); dwell3 = DW'(c.d3); st_total = DW'(c.st);
        ust_leg = c.ul; lst_leg = c.ll;
    endtask

    task automatic sync();
        do @(negedge clk); while (!period_start_o);
    endtask

    task automatic check_span(input cfg_t c, input int from, input int to, input bit bal, input string req);
        int nu = 0, nl = 0;
        for (int p = from; p < to; p++) begin
            logic [11:0] e;
            e = model(c, p);
            chk(gates_o === e, req, 32'(gates_o), 32'(e));
            chk(period_start_o === (p == 0), "R4", 32'(period_start_o), 32'(p == 0));
            for (int k = 0; k < 3; k++) begin
                if (gates_o[4*k +: 4] == 4'b1110) nu++;
                if (gates_o[4*k +: 4] == 4'b0111) nl++;
                chk(gates_o[4*k +: 4] != 4'hF, "R3", 32'(gates_o[4*k +: 4]), 32'h0);
            end
            @(negedge clk);
        end
        if (bal) begin
            chk(nu == nl, "R6 balance", 32'(nu), 32'(nl));
            chk(nu == exp_u(c), "R6 length", 32'(nu), 32'(exp_u(c)));
        end
    endtask

    task automatic run_full(input cfg_t c, input string req);
        apply(c);
        sync();
        check_span(c, 0, PERIOD, 1'b1, req);
    endtask

    // R2 and R4: reset state, idle first period, strobe placement
    task automatic test_reset();
        int n = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(gates_o === 12'h666, "R2 reset gates", 32'(gates_o), 32'h666);
        chk(period_start_o === 1'b0, "R2 reset strobe", 32'(period_start_o), 32'h0);
        rst = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (!period_start_o) chk(gates_o === 12'h666, "R2 first period", 32'(gates_o), 32'h666);
        end while (!period_start_o && n < 200);
        chk(n == PERIOD, "R4 first strobe", 32'(n), 32'(PERIOD));
    endtask

    // R1 R5: triangle without boost
    task automatic test_plain();
        run_full('{d2:16'd10, d3:16'd7, st:16'd0, ul:2'd3, ll:2'd3,
                   c1:6'b010110, c2:6'b000110, c3:6'b011010}, "R5 plain");
    endtask

    // R6 R8: boost in legs 1 and 2, leg 0 untouched
    task automatic test_boost();
        run_full('{d2:16'd10, d3:16'd7, st:16'd8, ul:2'd1, ll:2'd2,
                   c1:6'b010110, c2:6'b000110, c3:6'b011010}, "R6 R8 boost");
    endtask

    // R6: request larger than the zero-time room gets clamped
    task automatic test_boost_clamp();
        run_full('{d2:16'd10, d3:16'd7, st:16'd40, ul:2'd2, ll:2'd1,
                   c1:6'b010110, c2:6'b000110, c3:6'b011010}, "R6 clamp");
    endtask

    // R7: lower leg at P in first vector, and a disabled select
    task automatic test_suppress();
        run_full('{d2:16'd6, d3:16'd6, st:16'd10, ul:2'd1, ll:2'd0,
                   c1:6'b010110, c2:6'b000110, c3:6'b011010}, "R7 lower at P");
        run_full('{d2:16'd6, d3:16'd6, st:16'd10, ul:2'd3, ll:2'd2,
                   c1:6'b010101, c2:6'b010110, c3:6'b011010}, "R7 select off");
    endtask

    // R5: dwell sum above a period, remainder vector vanishes
    task automatic test_dwell_clip();
        run_full('{d2:16'd30, d3:16'd25, st:16'd12, ul:2'd1, ll:2'd2,
                   c1:6'b010101, c2:6'b000110, c3:6'b011010}, "R5 clip");
    endtask

    // R1: unused code 11 behaves as O, N legs encoded as 0011
    task automatic test_codes();
        run_full('{d2:16'd9, d3:16'd11, st:16'd6, ul:2'd0, ll:2'd2,
                   c1:6'b111101, c2:6'b000001, c3:6'b001000}, "R1 codes");
    endtask

    // R4: change inputs mid-period; old snapshot holds until next strobe
    task automatic test_midperiod();
        cfg_t a, b;
        a = '{d2:16'd10, d3:16'd7, st:16'd8, ul:2'd1, ll:2'd2,
              c1:6'b010110, c2:6'b000110, c3:6'b011010};
        b = '{d2:16'd4, d3:16'd14, st:16'd4, ul:2'd2, ll:2'd1,
              c1:6'b010101, c2:6'b010110, c3:6'b011010};
        apply(a);
        sync();
        check_span(a, 0, PERIOD / 2, 1'b0, "R4 before change");
        apply(b);
        check_span(a, PERIOD / 2, PERIOD, 1'b0, "R4 held");
        check_span(b, 0, PERIOD, 1'b1, "R4 new period");
    endtask

    initial begin
        test_reset();
        test_plain();
        test_boost();
        test_boost_clamp();
        test_suppress();
        test_dwell_clip();
        test_codes();
        test_midperiod();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule